// File: doc/BRIEF.md
# Host Byte FIFO with Command Capture

This block is the programmed-I/O data path between a host register port and a bus controller. The host pushes bytes with a write strobe and pulls them with a read strobe, and an occupancy count is exposed as a flags value. When the controller is in its command phase, host writes bypass the FIFO and are collected in a separate command buffer. The controller decodes that buffer elsewhere and then pulses a capture signal that empties both stores.

Two other controller events act on the FIFO. A status-response load replaces the FIFO contents with a status byte followed by a zero byte. A direction input marks the bus as data-out, and in that state host reads drain the count but return zero. Each successful read and each status load raise a level interrupt, which the host acknowledges. Writes into a FIFO that is one short of its depth are dropped, and they set a sticky overrun flag.

Top module: `pio_byte_fifo`

## Requirements
- R1: After reset, fifo_flags, cmd_len, host_rdata, irq and ovr_err are all zero.
- R2: While cmd_phase is high, a host write stores host_wdata into command slot cmd_len and increments cmd_len, leaving the FIFO count unchanged. Once cmd_len equals CMD_DEPTH, further command writes are dropped. Slot k reads back on cmd_byte when cmd_idx is k.
- R3: With cmd_phase low, a write while fifo_flags equals DEPTH-1 is discarded and sets ovr_err. ovr_err stays set until a cycle with err_rd, and a new overrun in that same cycle keeps it set. fifo_flags never exceeds DEPTH-1.
- R4: Any other host write with cmd_phase low appends the byte and raises fifo_flags by one. Bytes are read back in the order written.
- R5: A host read with fifo_flags nonzero lowers the count by one and sets irq. host_rdata takes the oldest byte on the clock edge of the read. With dir_out high, host_rdata becomes 0x00 and the oldest byte stays in place.
- R6: A host read with fifo_flags zero leaves host_rdata and irq unchanged.
- R7: Whenever the count becomes zero, both internal pointers rewind to slot zero. After draining by data-out reads, the next byte written is the next byte read.
- R8: A read and a write in the same cycle change fifo_flags by the net amount. A read of an empty FIFO is ignored while the write is kept.
- R9: rsp_load makes the FIFO hold rsp_status then 0x00, sets fifo_flags to 2 and sets irq, and it discards earlier contents. Host strobes to the FIFO in that cycle are ignored.
- R10: cmd_take clears fifo_flags, both pointers and cmd_len. It overrides rsp_load and every host strobe in the same cycle.
- R11: irq_ack clears irq, unless a read or a status load in the same cycle sets it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Host byte write strobe |
| host_wdata | input | 8 | Host write byte |
| host_rd | input | 1 | Host byte read strobe |
| host_rdata | output | 8 | Byte returned by the last successful read |
| cmd_phase | input | 1 | Route host writes to the command buffer |
| dir_out | input | 1 | Bus direction is data-out; reads return zero |
| cmd_take | input | 1 | Command consumed; clear FIFO and command buffer |
| cmd_idx | input | $clog2(CMD_DEPTH) | Command buffer slot to view |
| cmd_byte | output | 8 | Command buffer byte at cmd_idx |
| cmd_len | output | $clog2(CMD_DEPTH+1) | Bytes held in the command buffer |
| rsp_load | input | 1 | Load two-byte status response |
| rsp_status | input | 8 | Status byte for the response |
| fifo_flags | output | $clog2(DEPTH+1) | FIFO occupancy |
| irq | output | 1 | Interrupt request level |
| irq_ack | input | 1 | Interrupt acknowledge |
| ovr_err | output | 1 | Sticky overrun flag |
| err_rd | input | 1 | Host read of the overrun flag; clears it |

## Verification
The bench builds the block with DEPTH=4 and CMD_DEPTH=4. With these values the overrun limit is reached after three writes, and the command buffer fills after four. The pointer wrap and both saturation points therefore come up within a few dozen cycles. The same short depth lets the data-out drain case leave the pointers in a spot where a missing rewind returns a stale byte instead of the fresh one.

// File: rtl/pio_fifo_pkg.sv
package pio_fifo_pkg;

  // Occupancy after one cycle of push/pop activity.
  function automatic int occ_step(input int occ, input bit push, input bit pop);
    return occ + (push ? 1 : 0) - (pop ? 1 : 0);
  endfunction

  // Pointer advance that wraps at the storage depth.
  function automatic int wrap_inc(input int ptr, input int depth);
    return (ptr == depth - 1) ? 0 : ptr + 1;
  endfunction

  // A write is an overrun when the count sits one short of the depth.
  function automatic bit at_limit(input int occ, input int depth);
    return occ == depth - 1;
  endfunction

endpackage

// File: rtl/pio_fifo_store.sv
module pio_fifo_store
  import pio_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             load_rsp,
  input  logic [7:0]       rsp_status,
  input  logic             push,
  input  logic [7:0]       wdata,
  input  logic             advance,
  input  logic             drain,
  output logic [PTR_W-1:0] wptr,
  output logic [PTR_W-1:0] rptr,
  output logic [7:0]       head
);

  logic [7:0] mem [DEPTH];

  assign head = mem[rptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (clear) begin
      wptr <= '0;
      rptr <= '0;
    end else if (load_rsp) begin
      mem[0] <= rsp_status;
      mem[1] <= 8'h00;
      wptr   <= PTR_W'(2 % DEPTH);
      rptr   <= '0;
    end else begin
      if (push) mem[wptr] <= wdata;
      if (drain) begin
        wptr <= '0;
        rptr <= '0;
      end else begin
        if (push)    wptr <= PTR_W'(wrap_inc(int'(wptr), DEPTH));
        if (advance) rptr <= PTR_W'(wrap_inc(int'(rptr), DEPTH));
      end
    end
  end

endmodule

// File: rtl/pio_cmd_capture.sv
module pio_cmd_capture #(
  parameter int CMD_DEPTH = 32,
  localparam int CLEN_W = $clog2(CMD_DEPTH + 1),
  localparam int CIDX_W = $clog2(CMD_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              wr,
  input  logic [7:0]        wdata,
  input  logic [CIDX_W-1:0] idx,
  output logic [CLEN_W-1:0] len,
  output logic [7:0]        byte_out
);

  logic [7:0] buf_q [CMD_DEPTH];
  logic       room;

  assign room     = int'(len) < CMD_DEPTH;
  assign byte_out = buf_q[idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len <= '0;
      for (int i = 0; i < CMD_DEPTH; i++) buf_q[i] <= '0;
    end else if (clear) begin
      len <= '0;
    end else if (wr && room) begin
      buf_q[CIDX_W'(len)] <= wdata;
      len <= len + 1'b1;
    end
  end

endmodule

// File: rtl/pio_irq_err.sv
module pio_irq_err (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_set,
  input  logic irq_ack,
  input  logic err_set,
  input  logic err_rd,
  output logic irq,
  output logic ovr_err
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq     <= 1'b0;
      ovr_err <= 1'b0;
    end else begin
      if (irq_set)      irq <= 1'b1;
      else if (irq_ack) irq <= 1'b0;
      if (err_set)      ovr_err <= 1'b1;
      else if (err_rd)  ovr_err <= 1'b0;
    end
  end

endmodule

// File: rtl/pio_byte_fifo.sv
module pio_byte_fifo
  import pio_fifo_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int CMD_DEPTH = 32,
  localparam int PTR_W  = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int CLEN_W = $clog2(CMD_DEPTH + 1),
  localparam int CIDX_W = $clog2(CMD_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [7:0]        host_wdata,
  input  logic              host_rd,
  output logic [7:0]        host_rdata,
  input  logic              cmd_phase,
  input  logic              dir_out,
  input  logic              cmd_take,
  input  logic [CIDX_W-1:0] cmd_idx,
  output logic [7:0]        cmd_byte,
  output logic [CLEN_W-1:0] cmd_len,
  input  logic              rsp_load,
  input  logic [7:0]        rsp_status,
  output logic [CNT_W-1:0]  fifo_flags,
  output logic              irq,
  input  logic              irq_ack,
  output logic              ovr_err,
  input  logic              err_rd
);

  // Named internal events.
  logic             fifo_sel;
  logic             ev_cmd_wr;
  logic             ev_rsp;
  logic             ev_push;
  logic             ev_ovr;
  logic             ev_pop;
  logic             ev_advance;
  logic             ev_drain;
  logic [CNT_W-1:0] occ_q;
  logic [CNT_W-1:0] occ_nxt;
  logic [PTR_W-1:0] wptr;
  logic [PTR_W-1:0] rptr;
  logic [7:0]       head;

  assign fifo_sel   = !cmd_take && !rsp_load;
  assign ev_cmd_wr  = host_wr && cmd_phase && !cmd_take;
  assign ev_rsp     = rsp_load && !cmd_take;
  assign ev_ovr     = fifo_sel && host_wr && !cmd_phase && at_limit(int'(occ_q), DEPTH);
  assign ev_push    = fifo_sel && host_wr && !cmd_phase && !at_limit(int'(occ_q), DEPTH);
  assign ev_pop     = fifo_sel && host_rd && (occ_q != '0);
  assign ev_advance = ev_pop && !dir_out;
  assign occ_nxt    = CNT_W'(occ_step(int'(occ_q), ev_push, ev_pop));
  assign ev_drain   = (occ_nxt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        occ_q <= '0;
    else if (cmd_take) occ_q <= '0;
    else if (ev_rsp)   occ_q <= CNT_W'(2);
    else               occ_q <= occ_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      host_rdata <= '0;
    else if (ev_pop) host_rdata <= dir_out ? 8'h00 : head;
  end

  assign fifo_flags = occ_q;

  pio_fifo_store #(.DEPTH(DEPTH)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (cmd_take),
    .load_rsp   (ev_rsp),
    .rsp_status (rsp_status),
    .push       (ev_push),
    .wdata      (host_wdata),
    .advance    (ev_advance),
    .drain      (ev_drain),
    .wptr       (wptr),
    .rptr       (rptr),
    .head       (head)
  );

  pio_cmd_capture #(.CMD_DEPTH(CMD_DEPTH)) u_cmd (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (cmd_take),
    .wr       (ev_cmd_wr),
    .wdata    (host_wdata),
    .idx      (cmd_idx),
    .len      (cmd_len),
    .byte_out (cmd_byte)
  );

  pio_irq_err u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .irq_set (ev_pop || ev_rsp),
    .irq_ack (irq_ack),
    .err_set (ev_ovr),
    .err_rd  (err_rd),
    .irq     (irq),
    .ovr_err (ovr_err)
  );

endmodule

// File: rtl/pio_fifo_chk.sv
module pio_fifo_chk #(
  parameter int DEPTH     = 16,
  parameter int CMD_DEPTH = 32,
  localparam int PTR_W  = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int CLEN_W = $clog2(CMD_DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_wr,
  input logic              host_rd,
  input logic [7:0]        host_rdata,
  input logic              cmd_phase,
  input logic              cmd_take,
  input logic [CLEN_W-1:0] cmd_len,
  input logic              rsp_load,
  input logic [CNT_W-1:0]  fifo_flags,
  input logic              irq,
  input logic              irq_ack,
  input logic              ovr_err,
  input logic [PTR_W-1:0]  wptr,
  input logic [PTR_W-1:0]  rptr
);

  logic quiet;
  assign quiet = !cmd_take && !rsp_load;

  assert_cmd_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && cmd_phase && !cmd_take && int'(cmd_len) < CMD_DEPTH)
      |=> cmd_len == CLEN_W'($past(cmd_len) + 1'b1));

  assert_cmd_fifo_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && cmd_phase && !host_rd && quiet) |=> $stable(fifo_flags));

  assert_overrun_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && !cmd_phase && !host_rd && quiet && int'(fifo_flags) == DEPTH - 1)
      |=> (int'(fifo_flags) == DEPTH - 1) && ovr_err);

  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    int'(fifo_flags) <= DEPTH - 1);

  assert_pop_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && fifo_flags != '0 && quiet) |=> irq);

  assert_empty_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && !host_wr && fifo_flags == '0 && quiet) |=> $stable(host_rdata));

  assert_empty_ptrs_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_flags == '0) |-> (wptr == '0 && rptr == '0));

  assert_net_change_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_wr && !cmd_phase && quiet && fifo_flags != '0
       && int'(fifo_flags) != DEPTH - 1) |=> $stable(fifo_flags));

  assert_rsp_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_load && !cmd_take) |=> (fifo_flags == CNT_W'(2) && irq));

  assert_take_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_take |=> (fifo_flags == '0 && cmd_len == '0));

  assert_ack_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !(host_rd && fifo_flags != '0 && quiet) && !(rsp_load && !cmd_take))
      |=> !irq);

endmodule

bind pio_byte_fifo pio_fifo_chk #(.DEPTH(DEPTH), .CMD_DEPTH(CMD_DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .host_wr    (host_wr),
  .host_rd    (host_rd),
  .host_rdata (host_rdata),
  .cmd_phase  (cmd_phase),
  .cmd_take   (cmd_take),
  .cmd_len    (cmd_len),
  .rsp_load   (rsp_load),
  .fifo_flags (fifo_flags),
  .irq        (irq),
  .irq_ack    (irq_ack),
  .ovr_err    (ovr_err),
  .wptr       (wptr),
  .rptr       (rptr)
);

// File: tb/test_pio_byte_fifo.sv
module test_pio_byte_fifo;

  localparam int DEPTH     = 4;
  localparam int CMD_DEPTH = 4;
  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam int CLEN_W = $clog2(CMD_DEPTH + 1);
  localparam int CIDX_W = $clog2(CMD_DEPTH);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              host_wr = 1'b0;
  logic [7:0]        host_wdata = '0;
  logic              host_rd = 1'b0;
  logic [7:0]        host_rdata;
  logic              cmd_phase = 1'b0;
  logic              dir_out = 1'b0;
  logic              cmd_take = 1'b0;
  logic [CIDX_W-1:0] cmd_idx = '0;
  logic [7:0]        cmd_byte;
  logic [CLEN_W-1:0] cmd_len;
  logic              rsp_load = 1'b0;
  logic [7:0]        rsp_status = '0;
  logic [CNT_W-1:0]  fifo_flags;
  logic              irq;
  logic              irq_ack = 1'b0;
  logic              ovr_err;
  logic              err_rd = 1'b0;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  pio_byte_fifo #(.DEPTH(DEPTH), .CMD_DEPTH(CMD_DEPTH)) i_pio_byte_fifo (.*);

  // Vector: {op, write byte, expected host_rdata, expected fifo_flags}
  // op 0 = write, 1 = read, 2 = read and write together.
  localparam int NVEC = 13;
  localparam logic [20:0] VEC [NVEC] = '{
    {2'd0, 8'h11, 8'h00, 3'd1},
    {2'd0, 8'h22, 8'h00, 3'd2},
    {2'd0, 8'h33, 8'h00, 3'd3},
    {2'd0, 8'h44, 8'h00, 3'd3},   // overrun, dropped (R3)
    {2'd1, 8'h00, 8'h11, 3'd2},
    {2'd2, 8'h55, 8'h22, 3'd2},   // net change (R8)
    {2'd1, 8'h00, 8'h33, 3'd1},
    {2'd1, 8'h00, 8'h55, 3'd0},
    {2'd1, 8'h00, 8'h55, 3'd0},   // empty read ignored (R6)
    {2'd0, 8'h66, 8'h55, 3'd1},
    {2'd1, 8'h00, 8'h66, 3'd0},
    {2'd2, 8'h77, 8'h66, 3'd1},   // read of empty ignored, write kept (R8)
    {2'd1, 8'h00, 8'h77, 3'd0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Apply the strobes set by the caller for one clock edge, then drop them.
  task automatic tick();
    @(posedge clk);
    #1;
    host_wr  = 1'b0;
    host_rd  = 1'b0;
    cmd_take = 1'b0;
    rsp_load = 1'b0;
    irq_ack  = 1'b0;
    err_rd   = 1'b0;
  endtask

  task automatic wr(input logic [7:0] d);
    host_wr = 1'b1;
    host_wdata = d;
    tick();
  endtask

  task automatic rd();
    host_rd = 1'b1;
    tick();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (2) @(posedge clk);
    #1;
    chk("R1 flags", 32'(fifo_flags), 0);
    chk("R1 cmd_len", 32'(cmd_len), 0);
    chk("R1 rdata", 32'(host_rdata), 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 ovr_err", 32'(ovr_err), 0);
    rst_n = 1'b1;
    tick();

    for (int i = 0; i < NVEC; i++) begin
      host_wr    = (VEC[i][20:19] != 2'd1);
      host_rd    = (VEC[i][20:19] != 2'd0);
      host_wdata = VEC[i][18:11];
      tick();
      chk("R4 R5 vector rdata", 32'(host_rdata), 32'(VEC[i][10:3]));
      chk("R3 R8 vector flags", 32'(fifo_flags), 32'(VEC[i][2:0]));
    end

    // Sticky overrun and its clear (R3); read raised irq (R5)
    chk("R3 sticky", 32'(ovr_err), 1);
    chk("R5 irq set", 32'(irq), 1);
    err_rd = 1'b1;
    tick();
    chk("R3 cleared", 32'(ovr_err), 0);
    irq_ack = 1'b1;
    tick();
    chk("R11 ack", 32'(irq), 0);

    // Ack together with a read: the read wins (R11)
    wr(8'hA0);
    host_rd = 1'b1;
    irq_ack = 1'b1;
    tick();
    chk("R11 set wins", 32'(irq), 1);
    irq_ack = 1'b1;
    tick();

    // Data-out read returns zero and does not advance (R5)
    wr(8'hA1);
    wr(8'hB2);
    dir_out = 1'b1;
    rd();
    chk("R5 data-out zero", 32'(host_rdata), 0);
    chk("R5 data-out count", 32'(fifo_flags), 1);
    dir_out = 1'b0;
    rd();
    chk("R5 oldest kept", 32'(host_rdata), 32'hA1);

    // Drain by data-out reads, then pointers rewind (R7)
    wr(8'hC1);
    wr(8'hC2);
    wr(8'hC3);
    dir_out = 1'b1;
    rd();
    rd();
    rd();
    dir_out = 1'b0;
    chk("R7 drained", 32'(fifo_flags), 0);
    wr(8'hD4);
    rd();
    chk("R7 rewind", 32'(host_rdata), 32'hD4);

    // Command capture (R2)
    wr(8'hEE);
    cmd_phase = 1'b1;
    for (int k = 0; k < CMD_DEPTH + 1; k++) wr(8'h30 + 8'(k));
    cmd_phase = 1'b0;
    chk("R2 len saturates", 32'(cmd_len), CMD_DEPTH);
    chk("R2 fifo untouched", 32'(fifo_flags), 1);
    for (int k = 0; k < CMD_DEPTH; k++) begin
      cmd_idx = CIDX_W'(k);
      #1;
      chk("R2 cmd byte", 32'(cmd_byte), 32'h30 + k);
    end

    // Capture clears both stores, overriding rsp_load (R10)
    wr(8'hEF);
    cmd_take = 1'b1;
    rsp_load = 1'b1;
    rsp_status = 8'h99;
    host_wr = 1'b1;
    host_wdata = 8'h12;
    tick();
    chk("R10 flags clear", 32'(fifo_flags), 0);
    chk("R10 len clear", 32'(cmd_len), 0);

    // Status response (R9)
    irq_ack = 1'b1;
    tick();
    wr(8'h01);
    wr(8'h02);
    wr(8'h03);
    rsp_load = 1'b1;
    rsp_status = 8'h5A;
    host_wr = 1'b1;
    host_wdata = 8'h77;
    tick();
    chk("R9 flags two", 32'(fifo_flags), 2);
    chk("R9 irq", 32'(irq), 1);
    rd();
    chk("R9 status byte", 32'(host_rdata), 32'h5A);
    rd();
    chk("R9 zero byte", 32'(host_rdata), 0);
    chk("R9 empty", 32'(fifo_flags), 0);

    finish_run();
  end

endmodule